// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block is the processor-side sequencer for instruction fetch on a bus whose low eight lines carry both address and data. It divides the incoming oscillator by two to make the bus clock. It then steps through four bus states per fetch. The first state puts the program counter out: the high byte goes to dedicated lines and the low byte to the shared lines, while the address-latch strobe is high. The second and third states hold the active-low read strobe low, and the byte returned in the third state is captured. The fourth state presents the captured opcode to the decode logic and the bus stays quiet.

The program counter advances by one after every fetch, and the next fetch follows at once. An active-low reset clears the counter and raises a reset-out indication. A hold request is looked at only when a fetch ends. While hold is granted, the block releases the bus and raises its acknowledge. The shared lines are modelled as separate in/out buses plus an output enable, so the pad ring makes the actual tri-state. The enable for the high-address and control lines does the same job, and a low value means those pins are floated.

Top module: `fetch_seq`

## Requirements
- R1: In state T1, `addr_hi` equals PC[15:8], `ad_out` equals PC[7:0] with `ad_en`=1, `ale`=1, `io_mem`=0 (0 marks memory), `rd_n`=1 and `wr_n`=1.
- R2: In state T2, `ale`=0, `rd_n`=0 and `ad_en`=0, so the shared lines are turned around for the returning data.
- R3: In state T3, `rd_n` stays 0, and the value on `ad_in` at the end of T3 is the byte that gets captured.
- R4: In state T4, `rd_n`=1, `ad_en`=0, `opcode` holds the byte captured in T3, and `opcode_vld`=1. `opcode_vld` is 1 in no other state.
- R5: After each fetch, the next fetch uses PC+1. When no hold is granted, its T1 starts in the bus cycle right after T4.
- R6: While `rst_in_n`=0: `rst_out`=1, `rd_n`=1, `ale`=0, `ad_en`=0 and `hold_ack`=0, whatever `hold_req` is. After release, the first T1 presents address 0.
- R7: `hold_req` is sampled only at the end of T4. A request that rises and falls within a fetch has no effect, and `hold_ack` stays 0 during a fetch.
- R8: While hold is granted, `hold_ack`=1, `bus_en`=0 (address-high and control pins floated) and `ad_en`=0. When `hold_req` drops, the next T1 presents the PC that follows the last fetch.
- R9: `bus_clk` toggles on every oscillator cycle, and each T-state lasts two oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_in_n | input | 1 | Active-low asynchronous reset |
| hold_req | input | 1 | External request for the bus |
| ad_in | input | 8 | Shared lines, value read from the pads |
| ad_out | output | 8 | Shared lines, value driven to the pads |
| ad_en | output | 1 | Output enable for the shared lines |
| addr_hi | output | 8 | High address byte |
| bus_en | output | 1 | Enable for addr_hi and control pins, 0 = floated |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe (fetch never writes) |
| io_mem | output | 1 | 1 = I/O access, 0 = memory access |
| bus_clk | output | 1 | Bus clock, half the oscillator rate |
| rst_out | output | 1 | Reset indication for external logic |
| hold_ack | output | 1 | Hold granted |
| opcode | output | 8 | Captured opcode |
| opcode_vld | output | 1 | Opcode valid, high in T4 |

## Verification
A wrong state register shows up within one bus cycle, as a strobe pattern that is not allowed: ALE with read low, read low with the shared lines driven, or a valid pulse while read is low. A wrong program counter shows up at the very next T1 as an address that does not match the bench's count. Capture at the wrong time shows up in T4 of the same fetch, because memory returns an address-dependent byte. A hold decision made at the wrong moment shows up in the bus cycle after T4, as a missing or misplaced acknowledge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_HOLD = 3'd5
  } tstate_e;
endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fetch_clk_div.sv
module fetch_clk_div (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic ce
);
  logic phase_d;

  always_comb phase_d = ~phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= phase_d;
  end

  assign ce = phase;
endmodule

// File: rtl/fetch_fsm.sv
module fetch_fsm
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              hold_req,
  input  logic [DATA_W-1:0] ad_in,
  output tstate_e           st,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir
);
  tstate_e           st_d;
  logic [ADDR_W-1:0] pc_d;
  logic [DATA_W-1:0] ir_d;

  always_comb begin
    st_d = st;
    pc_d = pc;
    ir_d = ir;
    unique case (st)
      ST_IDLE: st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3: begin
        st_d = ST_T4;
        ir_d = ad_in;
      end
      ST_T4: begin
        pc_d = pc + 1'b1;
        st_d = hold_req ? ST_HOLD : ST_T1;
      end
      ST_HOLD: st_d = hold_req ? ST_HOLD : ST_T1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= '0;
      ir <= '0;
    end else if (ce) begin
      st <= st_d;
      pc <= pc_d;
      ir <= ir_d;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              osc_clk,
  input  logic              rst_in_n,
  input  logic              hold_req,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_en,
  output logic [HI_W-1:0]   addr_hi,
  output logic              bus_en,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_mem,
  output logic              bus_clk,
  output logic              rst_out,
  output logic              hold_ack,
  output logic [DATA_W-1:0] opcode,
  output logic              opcode_vld
);
  logic              rst_n_s;
  logic              ce;
  tstate_e           st;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;

  fetch_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(osc_clk), .arst_n(rst_in_n), .srst_n(rst_n_s)
  );

  fetch_clk_div u_div (
    .clk(osc_clk), .rst_n(rst_n_s), .phase(bus_clk), .ce(ce)
  );

  fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(osc_clk), .rst_n(rst_n_s), .ce(ce), .hold_req(hold_req),
    .ad_in(ad_in), .st(st), .pc(pc), .ir(ir)
  );

  always_comb begin
    ad_out     = pc[DATA_W-1:0];
    addr_hi    = pc[ADDR_W-1:DATA_W];
    ad_en      = (st == ST_T1);
    ale        = (st == ST_T1);
    rd_n       = !((st == ST_T2) || (st == ST_T3));
    wr_n       = 1'b1;
    io_mem     = 1'b0;
    bus_en     = (st != ST_HOLD);
    hold_ack   = (st == ST_HOLD);
    opcode     = ir;
    opcode_vld = (st == ST_T4);
    rst_out    = !rst_n_s;
  end
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk (
  input logic osc_clk,
  input logic rst_out,
  input logic ale,
  input logic rd_n,
  input logic ad_en,
  input logic bus_en,
  input logic hold_ack,
  input logic opcode_vld,
  input logic bus_clk
);
  AST_ALE_DRIVES_BUS: assert property (@(posedge osc_clk) disable iff (rst_out)
    ale |-> (ad_en && bus_en && rd_n)); // R1
  AST_READ_TURNAROUND: assert property (@(posedge osc_clk) disable iff (rst_out)
    !rd_n |-> (!ad_en && !ale)); // R2
  AST_VLD_READ_DONE: assert property (@(posedge osc_clk) disable iff (rst_out)
    opcode_vld |-> (rd_n && !ad_en)); // R4
  AST_RESET_QUIET: assert property (@(posedge osc_clk)
    rst_out |-> (rd_n && !ale && !hold_ack && !ad_en)); // R6
  AST_HOLD_FLOATS: assert property (@(posedge osc_clk) disable iff (rst_out)
    hold_ack |-> (!bus_en && !ad_en && !opcode_vld)); // R8
  AST_BUS_CLK_TOGGLE: assert property (@(posedge osc_clk) disable iff (rst_out)
    1'b1 |=> (bus_clk != $past(bus_clk))); // R9
endmodule

bind fetch_seq fetch_seq_chk u_chk (
  .osc_clk(osc_clk), .rst_out(rst_out), .ale(ale), .rd_n(rd_n),
  .ad_en(ad_en), .bus_en(bus_en), .hold_ack(hold_ack),
  .opcode_vld(opcode_vld), .bus_clk(bus_clk)
);

// File: tb/fetch_seq_bench.sv
module fetch_seq_bench;
  logic       osc_clk = 1'b0;
  logic       rst_in_n;
  logic       hold_req;
  logic [7:0] ad_in;
  logic [7:0] ad_out;
  logic       ad_en;
  logic [7:0] addr_hi;
  logic       bus_en, ale, rd_n, wr_n, io_mem, bus_clk, rst_out, hold_ack;
  logic [7:0] opcode;
  logic       opcode_vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [15:0] lat_addr = '0;

  always #5 osc_clk = ~osc_clk;

  fetch_seq u_fetch_seq (
    .osc_clk(osc_clk), .rst_in_n(rst_in_n), .hold_req(hold_req),
    .ad_in(ad_in), .ad_out(ad_out), .ad_en(ad_en), .addr_hi(addr_hi),
    .bus_en(bus_en), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_mem(io_mem),
    .bus_clk(bus_clk), .rst_out(rst_out), .hold_ack(hold_ack),
    .opcode(opcode), .opcode_vld(opcode_vld)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model: latch the address on ALE, return data while read is low
  always @(negedge osc_clk) if (ale) lat_addr = {addr_hi, ad_out};
  always_comb ad_in = (!rd_n) ? mem_byte(lat_addr) : 8'h00;

  always @(posedge osc_clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ale();
    for (int k = 0; k < 60; k++) begin
      if (ale) return;
      @(negedge osc_clk);
    end
    chk(1'b0, "R5 no T1 found", 0, 1);
  endtask

  // entered at the first negedge of T1
  task automatic one_fetch(input logic [15:0] pc, input int mode);
    chk({addr_hi, ad_out} == pc, "R1 address", {addr_hi, ad_out}, pc);
    chk(ad_en && ale && !io_mem && rd_n && wr_n && bus_en, "R1 strobes",
        {ad_en, ale, io_mem, rd_n, wr_n}, 5'b11011);
    if (mode == 2) hold_req = 1'b1;
    repeat (2) @(negedge osc_clk);
    chk(!ale && !rd_n && !ad_en, "R2 turnaround", {ale, rd_n, ad_en}, 0);
    repeat (2) @(negedge osc_clk);
    chk(!rd_n && !opcode_vld, "R3 read held", {rd_n, opcode_vld}, 0);
    chk(!hold_ack, "R7 no ack mid-fetch", hold_ack, 0);
    if (mode == 2) hold_req = 1'b0;
    if (mode == 3) hold_req = 1'b1;
    repeat (2) @(negedge osc_clk);
    chk(rd_n && !ad_en && opcode_vld, "R4 T4 strobes", {rd_n, ad_en, opcode_vld}, 3'b101);
    chk(opcode == mem_byte(pc), "R4 opcode", opcode, mem_byte(pc));
    repeat (2) @(negedge osc_clk);
    if (mode == 3) begin
      int n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) begin
        chk(hold_ack && !bus_en && !ad_en, "R8 hold float",
            {hold_ack, bus_en, ad_en}, 3'b100);
        repeat (2) @(negedge osc_clk);
      end
      hold_req = 1'b0;
      wait_ale();
    end else begin
      chk(ale && !hold_ack, "R5 back-to-back T1 / R7 pulse ignored", {ale, hold_ack}, 2'b10);
    end
  endtask

  initial begin
    logic [15:0] exp_pc;
    logic        prev;
    void'($urandom(32'd1234));
    rst_in_n = 1'b0;
    hold_req = 1'b1;
    repeat (3) @(negedge osc_clk);
    chk(rst_out && rd_n && !ale && !ad_en && !hold_ack, "R6 reset state",
        {rst_out, rd_n, ale, ad_en, hold_ack}, 5'b11000);
    hold_req = 1'b0;
    rst_in_n = 1'b1;
    wait_ale();
    chk(!rst_out, "R6 reset released", rst_out, 0);
    prev = bus_clk;
    for (int k = 0; k < 4; k++) begin
      @(negedge osc_clk);
      chk(bus_clk != prev, "R9 bus clock toggle", bus_clk, !prev);
      prev = bus_clk;
    end
    chk(ale == 1'b0, "R9 T1 lasts two cycles", ale, 0);
    wait_ale();
    exp_pc = 16'd1;
    chk({addr_hi, ad_out} == 16'd1, "R5 second fetch", {addr_hi, ad_out}, 1);
    // directed: pulse, then a granted hold
    one_fetch(exp_pc, 2); exp_pc = exp_pc + 1'b1;
    one_fetch(exp_pc, 3); exp_pc = exp_pc + 1'b1;
    for (int i = 0; i < 60; i++) begin
      one_fetch(exp_pc, int'($urandom % 4));
      exp_pc = exp_pc + 1'b1;
    end
    // reset in the middle of a fetch, with hold requested
    repeat (2) @(negedge osc_clk);
    rst_in_n = 1'b0;
    hold_req = 1'b1;
    #1;
    chk(rst_out && rd_n && !ale && !hold_ack, "R6 mid-run reset",
        {rst_out, rd_n, ale, hold_ack}, 4'b1100);
    repeat (4) @(negedge osc_clk);
    chk(!hold_ack, "R6 hold ignored in reset", hold_ack, 0);
    hold_req = 1'b0;
    rst_in_n = 1'b1;
    wait_ale();
    chk({addr_hi, ad_out} == 16'd0, "R6 restart at zero", {addr_hi, ad_out}, 0);
    one_fetch(16'd0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule